// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

The block is a sequential integer divider that produces one quotient bit on each clock. It divides a dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. The dividend is either a full 32-bit value, supplied as an upper and a lower half-word, or a 16-bit value taken from the lower half-word alone. Signed and unsigned operands share one datapath. The operands are converted to magnitudes, divided by restoring iteration, and the signs are put back in a final correction cycle. As a result, every operation takes the same number of cycles, whatever the dividend size or signedness.

A pipeline or sequencer presents the operands with a one-cycle start pulse and then waits for the single-cycle done pulse. The quotient, remainder and two exception flags are registered. They stay stable until the next operation completes. A zero divisor and a quotient that cannot be represented in 16 bits are both reported. Each returns a fixed, predictable result pattern.

Top module: `int_divider`

## Requirements
- R1: With `wide_i`=1 the dividend is {`dvd_hi_i`,`dvd_lo_i`}. With `wide_i`=0 only `dvd_lo_i` is used: it is sign-extended when `signed_i`=1 and zero-extended when `signed_i`=0, and `dvd_hi_i` has no effect on any output.
- R2: With `signed_i`=0 the operands are unsigned, `quot_o` is the integer quotient and `rem_o` is the remainder.
- R3: With `signed_i`=1 the operands are two's complement. The quotient is truncated toward zero, and a non-zero remainder carries the sign of the dividend.
- R4: When `start_i` is high at a rising edge k while `busy_o` is low, `busy_o` is high from edge k to edge k+17, and `done_o` is high for exactly one cycle, from edge k+17 to edge k+18. This timing is the same for both dividend sizes and both signedness modes.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes with its original operands and its original timing.
- R6: A zero divisor sets `dz_o`=1 and `ovf_o`=0, and returns `quot_o`=16'hFFFF and `rem_o`=`dvd_lo_i`.
- R7: A non-zero divisor whose exact quotient lies outside 0..65535 (unsigned) or outside -32768..32767 (signed) sets `ovf_o`=1 and `dz_o`=0, and returns `quot_o`=16'hFFFF and `rem_o`=`dvd_lo_i`. Otherwise both flags are 0.
- R8: `quot_o`, `rem_o`, `dz_o` and `ovf_o` change only at the edge that raises `done_o`, and hold until the next such edge. A start in the cycle where `done_o` is high is accepted.
- R9: After reset, `busy_o`, `done_o`, `quot_o`, `rem_o`, `dz_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| signed_i | input | 1 | 1 = two's complement operands |
| wide_i | input | 1 | 1 = 32-bit dividend, 0 = 16-bit dividend |
| dvd_hi_i | input | 16 | Upper half of the dividend |
| dvd_lo_i | input | 16 | Lower half of the dividend |
| dvs_i | input | 16 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| dz_o | output | 1 | Divisor was zero |
| ovf_o | output | 1 | Quotient did not fit in 16 bits |

## Verification
Two functions can fall in the same cycle. The first pair is the completion of one division and the acceptance of the next: the bench raises a new start in exactly the cycle where `done_o` is high. It then judges that the old results appear, that the new operation runs its full 17 busy cycles, and that the old results stay in place until the new done pulse. The second pair is a running iteration and an incoming start: a start with different operands is injected mid-operation. The reference model ignores that start, so any reload or timing slip shows up as a mismatch on the cycle-by-cycle comparison of busy, done and results.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic is_signed;
    logic dvd_neg;
    logic dvs_neg;
    logic dvs_zero;
    logic pre_ovf;
  } div_mode_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int DW = 16
) (
  input  logic          signed_i,
  input  logic          wide_i,
  input  logic [DW-1:0] dvd_hi_i,
  input  logic [DW-1:0] dvd_lo_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] mag_hi_o,
  output logic [DW-1:0] mag_lo_o,
  output logic [DW-1:0] mag_dvs_o,
  output div_pkg::div_mode_t mode_o
);
  localparam int XW = 2 * DW;

  function automatic logic [XW-1:0] negate_x(input logic [XW-1:0] v);
    return ~v + XW'(1);
  endfunction

  function automatic logic [DW-1:0] negate_w(input logic [DW-1:0] v);
    return ~v + DW'(1);
  endfunction

  logic [XW-1:0] ext_dvd;
  logic [XW-1:0] mag_dvd;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    if (wide_i) ext_dvd = {dvd_hi_i, dvd_lo_i};
    else        ext_dvd = {{DW{signed_i & dvd_lo_i[DW-1]}}, dvd_lo_i};
    dvd_neg   = signed_i & ext_dvd[XW-1];
    dvs_neg   = signed_i & dvs_i[DW-1];
    mag_dvd   = dvd_neg ? negate_x(ext_dvd) : ext_dvd;
    mag_dvs_o = dvs_neg ? negate_w(dvs_i) : dvs_i;
    mag_hi_o  = mag_dvd[XW-1:DW];
    mag_lo_o  = mag_dvd[DW-1:0];
    mode_o.is_signed = signed_i;
    mode_o.dvd_neg   = dvd_neg;
    mode_o.dvs_neg   = dvs_neg;
    mode_o.dvs_zero  = (dvs_i == '0);
    mode_o.pre_ovf   = (mag_dvd[XW-1:DW] >= mag_dvs_o);
  end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl #(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_evt_o,
  output logic step_evt_o,
  output logic fix_evt_o,
  output logic busy_o
);
  import div_pkg::*;
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          ignored_start;

  assign busy_o        = (state_q != ST_IDLE);
  assign load_evt_o    = (state_q == ST_IDLE) && start_i;
  assign step_evt_o    = (state_q == ST_ITER);
  assign fix_evt_o     = (state_q == ST_FIX);
  assign ignored_start = busy_o && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ITER;
          cnt_q   <= '0;
        end
        ST_ITER: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_IGNORED_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_start && step_evt_o && (cnt_q != LAST) |=> step_evt_o && (cnt_q == $past(cnt_q) + CW'(1))); // R5
  AST_FIX_FOLLOWS_ITER: assert property (@(posedge clk) disable iff (!rst_n)
    fix_evt_o |-> $past(step_evt_o)); // R4
endmodule

// File: rtl/div_iter_core.sv
module div_iter_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] mag_hi_i,
  input  logic [DW-1:0] mag_lo_i,
  input  logic [DW-1:0] mag_dvs_i,
  output logic [DW-1:0] part_rem_o,
  output logic [DW-1:0] part_quo_o,
  output logic [DW-1:0] held_dvs_o
);
  localparam int SW = DW + 2;

  // one restoring step: returns {next remainder, quotient bit}
  function automatic logic [DW:0] restore_step(input logic [DW-1:0] rem,
                                               input logic          in_bit,
                                               input logic [DW-1:0] dvs);
    logic [SW-1:0] trial;
    trial = {1'b0, rem, in_bit} - {2'b00, dvs};
    if (trial[SW-1]) return {rem[DW-2:0], in_bit, 1'b0};
    else             return {trial[DW-1:0], 1'b1};
  endfunction

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [DW:0]   nxt;

  assign nxt = restore_step(rem_q, quo_q[DW-1], dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= mag_hi_i;
      quo_q <= mag_lo_i;
      dvs_q <= mag_dvs_i;
    end else if (step_i) begin
      rem_q <= nxt[DW:1];
      quo_q <= {quo_q[DW-2:0], nxt[0]};
    end
  end

  assign part_rem_o = rem_q;
  assign part_quo_o = quo_q;
  assign held_dvs_o = dvs_q;

  AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(dvs_q)); // R5
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               fix_i,
  input  div_pkg::div_mode_t mode_i,
  input  logic [DW-1:0]      dvd_lo_i,
  input  logic [DW-1:0]      mag_quo_i,
  input  logic [DW-1:0]      mag_rem_i,
  output logic [DW-1:0]      quot_o,
  output logic [DW-1:0]      rem_o,
  output logic               dz_o,
  output logic               ovf_o,
  output logic               done_o,
  output logic               pre_ovf_o
);
  import div_pkg::*;
  localparam logic [DW-1:0] MIN_MAG = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] apply_sign(input logic neg, input logic [DW-1:0] v);
    return neg ? (~v + DW'(1)) : v;
  endfunction

  function automatic logic fits_signed(input logic neg, input logic [DW-1:0] mag);
    return neg ? (mag <= MIN_MAG) : !mag[DW-1];
  endfunction

  div_mode_t     mode_q;
  logic [DW-1:0] lo_q;
  logic          neg_quo, neg_rem, range_bad, ovf_now;

  always_comb begin
    neg_quo   = mode_q.is_signed & (mode_q.dvd_neg ^ mode_q.dvs_neg);
    neg_rem   = mode_q.is_signed & mode_q.dvd_neg;
    range_bad = mode_q.pre_ovf | (mode_q.is_signed & !fits_signed(neg_quo, mag_quo_i));
    ovf_now   = !mode_q.dvs_zero & range_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      quot_o <= '0;
      rem_o  <= '0;
      dz_o   <= 1'b0;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= fix_i;
      if (load_i) begin
        mode_q <= mode_i;
        lo_q   <= dvd_lo_i;
      end
      if (fix_i) begin
        dz_o  <= mode_q.dvs_zero;
        ovf_o <= ovf_now;
        if (mode_q.dvs_zero || ovf_now) begin
          quot_o <= '1;
          rem_o  <= lo_q;
        end else begin
          quot_o <= apply_sign(neg_quo, mag_quo_i);
          rem_o  <= apply_sign(neg_rem, mag_rem_i);
        end
      end
    end
  end

  assign pre_ovf_o = mode_q.pre_ovf;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(dz_o && ovf_o)); // R7
  AST_ZERO_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && dz_o |-> (quot_o == '1) && (rem_o == lo_q)); // R6
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !dz_o && !ovf_o && mode_q.is_signed && (rem_o != '0)
    |-> rem_o[DW-1] == mode_q.dvd_neg); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quot_o) && $stable(rem_o) && $stable(dz_o) && $stable(ovf_o)); // R8
endmodule

// File: rtl/int_divider.sv
module int_divider #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic          wide_i,
  input  logic [DW-1:0] dvd_hi_i,
  input  logic [DW-1:0] dvd_lo_i,
  input  logic [DW-1:0] dvs_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o,
  output logic          dz_o,
  output logic          ovf_o
);
  import div_pkg::*;
  localparam int LW = $clog2(DW + 2) + 1;

  logic          load_evt, step_evt, fix_evt;
  logic [DW-1:0] mag_hi, mag_lo, mag_dvs;
  logic [DW-1:0] part_rem, part_quo, held_dvs;
  logic          pre_ovf_held;
  div_mode_t     mode;

  div_seq_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_evt_o(load_evt), .step_evt_o(step_evt), .fix_evt_o(fix_evt),
    .busy_o(busy_o)
  );

  div_operand_prep #(.DW(DW)) u_prep (
    .signed_i(signed_i), .wide_i(wide_i),
    .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .mag_hi_o(mag_hi), .mag_lo_o(mag_lo), .mag_dvs_o(mag_dvs),
    .mode_o(mode)
  );

  div_iter_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .step_i(step_evt),
    .mag_hi_i(mag_hi), .mag_lo_i(mag_lo), .mag_dvs_i(mag_dvs),
    .part_rem_o(part_rem), .part_quo_o(part_quo), .held_dvs_o(held_dvs)
  );

  div_result_fix #(.DW(DW)) u_fix (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .fix_i(fix_evt),
    .mode_i(mode), .dvd_lo_i(dvd_lo_i),
    .mag_quo_i(part_quo), .mag_rem_i(part_rem),
    .quot_o(quot_o), .rem_o(rem_o), .dz_o(dz_o), .ovf_o(ovf_o),
    .done_o(done_o), .pre_ovf_o(pre_ovf_held)
  );

  // latency observer for the assertions below
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (load_evt) lat_q <= '0;
    else if (busy_o)   lat_q <= lat_q + LW'(1);
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fix_evt |-> lat_q == LW'(DW)); // R4
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R4
  AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt && !pre_ovf_held |=> part_rem < held_dvs); // R2
endmodule

// File: tb/int_divider_tb_top.sv
module int_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0, wide = 1'b0;
  logic [15:0] hi = '0, lo = '0, dvs = '0;
  logic        busy_o, done_o, dz_o, ovf_o;
  logic [15:0] quot_o, rem_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  int_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn), .wide_i(wide),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvs_i(dvs),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o),
    .dz_o(dz_o), .ovf_o(ovf_o)
  );

  // behavioural reference: exact integer arithmetic on 64-bit values
  task automatic ref_div(input bit s, input bit w, input logic [15:0] h, input logic [15:0] l,
                         input logic [15:0] d, output logic [15:0] q, output logic [15:0] r,
                         output bit dz, output bit ov);
    longint n, dv, qq, rr;
    if (w) begin
      n = longint'({32'd0, h, l});
      if (s && h[15]) n = n - 64'sh1_0000_0000;
    end else begin
      n = longint'({48'd0, l});
      if (s && l[15]) n = n - 65536;
    end
    dv = longint'({48'd0, d});
    if (s && d[15]) dv = dv - 65536;
    dz = (d == 16'h0);
    ov = 1'b0;
    q = 16'hFFFF;
    r = l;
    if (!dz) begin
      qq = n / dv;
      rr = n % dv;
      ov = s ? (qq > 32767 || qq < -32768) : (qq > 65535);
      if (!ov) begin
        q = qq[15:0];
        r = rr[15:0];
      end
    end
  endtask

  // cycle model
  int          cnt = 0;
  logic        e_done = 0, e_dz = 0, e_ov = 0;
  logic [15:0] e_q = 0, e_r = 0, p_q = 0, p_r = 0;
  bit          p_dz = 0, p_ov = 0;
  string       p_tag = "R2", e_tag = "R9";
  bit          intruded = 0;

  function automatic string pick_tag(bit s, bit w, bit dz, bit ov);
    if (dz) return "R6";
    if (ov) return "R7";
    if (!w) return "R1";
    if (s)  return "R3";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; e_done <= 0; e_q <= 0; e_r <= 0; e_dz <= 0; e_ov <= 0;
    end else begin
      e_done <= 1'b0;
      if (cnt == 0) begin
        if (start) begin
          logic [15:0] tq, tr;
          bit tdz, tov;
          ref_div(sgn, wide, hi, lo, dvs, tq, tr, tdz, tov);
          p_q <= tq; p_r <= tr; p_dz <= tdz; p_ov <= tov;
          p_tag <= pick_tag(sgn, wide, tdz, tov);
          intruded <= 1'b0;
          cnt <= 17;
        end
      end else begin
        if (start) intruded <= 1'b1;
        cnt <= cnt - 1;
        if (cnt == 1) begin
          e_done <= 1'b1;
          e_q <= p_q; e_r <= p_r; e_dz <= p_dz; e_ov <= p_ov;
          e_tag <= intruded ? "R5" : p_tag;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string rt;
      rt = e_done ? e_tag : "R8";
      chk("R4", "busy", 32'(busy_o), 32'(cnt != 0));
      chk("R4", "done", 32'(done_o), 32'(e_done));
      chk(rt, "quot", 32'(quot_o), 32'(e_q));
      chk(rt, "rem",  32'(rem_o),  32'(e_r));
      chk(e_done ? "R6" : "R8", "dz",  32'(dz_o),  32'(e_dz));
      chk(e_done ? "R7" : "R8", "ovf", 32'(ovf_o), 32'(e_ov));
    end
  end

  task automatic run_op(input bit s, input bit w, input logic [15:0] h, input logic [15:0] l,
                        input logic [15:0] d);
    while (busy_o) @(negedge clk);
    start = 1'b1; sgn = s; wide = w; hi = h; lo = l; dvs = d;
    @(negedge clk);
    start = 1'b0;
    hi = 16'hDEAD; lo = 16'hBEEF; dvs = 16'h0;  // operands no longer matter
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values, checked while reset is still applied
    chk("R9", "busy", 32'(busy_o), 0);
    chk("R9", "done", 32'(done_o), 0);
    chk("R9", "quot", 32'(quot_o), 0);
    chk("R9", "rem",  32'(rem_o),  0);
    chk("R9", "flags", 32'({dz_o, ovf_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 unsigned wide and narrow
    run_op(0, 1, 16'h0001, 16'h0000, 16'h0002);   // 0x8000 r0
    run_op(0, 0, 16'h1234, 16'd1000, 16'd7);      // R1 hi ignored
    run_op(0, 0, 16'hFFFF, 16'hFFFF, 16'h0001);   // R1 zero-extension, 0xFFFF fits
    // R3 signed truncation
    run_op(1, 0, 16'h5555, 16'hFFF9, 16'h0002);   // -7/2  -> -3 r -1
    run_op(1, 0, 16'h0000, 16'h0007, 16'hFFFE);   // 7/-2  -> -3 r 1
    run_op(1, 1, 16'hFFFF, 16'hFF00, 16'h0010);   // -256/16
    run_op(1, 1, 16'hFFFF, 16'h8000, 16'h0001);   // -32768 fits
    run_op(1, 0, 16'h0000, 16'h8000, 16'h0001);   // -32768 fits
    // R6 divide by zero
    run_op(0, 1, 16'h0012, 16'h3456, 16'h0000);
    run_op(1, 0, 16'h0000, 16'h8001, 16'h0000);
    // R7 overflow
    run_op(1, 1, 16'h8000, 16'h0000, 16'hFFFF);   // most negative / -1
    run_op(0, 1, 16'h0002, 16'h0000, 16'h0002);   // 0x10000
    run_op(1, 0, 16'h0000, 16'h8000, 16'hFFFF);   // 32768
    run_op(1, 1, 16'h0000, 16'h8000, 16'h0001);   // +32768 does not fit
    wait_idle();

    // R5: start pulses with other operands while busy
    run_op(0, 1, 16'h0003, 16'h1111, 16'h0101);
    repeat (5) @(negedge clk);
    start = 1'b1; sgn = 1; wide = 0; lo = 16'h0001; dvs = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R8: back-to-back, next start raised in the done cycle
    run_op(0, 1, 16'h0000, 16'd5000, 16'd3);
    while (!done_o) @(negedge clk);
    start = 1'b1; sgn = 1; wide = 1; hi = 16'hFFFF; lo = 16'hF000; dvs = 16'h0007;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] rd;
      rd = 16'($urandom);
      case (i % 5)
        0: rd = 16'h0;
        1: rd = rd & 16'h000F;
        default: ;
      endcase
      run_op(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), rd);
    end
    wait_idle();
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule